// File: doc/BRIEF.md
# Software SMI Generator with Block Timer

This power-management block turns a software write to a trigger register into a system-management request. It can signal the request in one of two ways. The first is a level on an SMI output, which stays high until the processor side acknowledges it. The second is a one-cycle request on one of four interrupt lines, chosen by a small CPU-selection field.

After each request the block locks out further software requests. A count-down counter, clocked by a divided timebase tick, lifts the lockout when it runs out. Software programs the lockout length by writing the block-count register. It can restart the current timebase period through a second bit of the trigger register.

Every request also sets a sticky status bit, which software clears by writing one to it. All registers sit on one byte-wide port with a shared address. Writes are synchronous and reads are combinational.

Top module: `swsmi_gen`

## Requirements
- R1: After reset every register address reads 00h, `smi_o` is low and `irq_req` is zero.
- R2: Address 0 (power configuration) and address 2 (request-select low) keep all 8 written bits. Address 1 (CPU select) keeps only the bits under mask 9Fh. Address 3 (request-select high) keeps only the bits under mask 7Fh.
- R3: A write to address 7 (trigger) produces a request only when all four of these hold: written bit 0 is 1, configuration bit 7 is 1, request-select low bit 4 is 1, and no lockout is active.
- R4: If configuration bit 4 is 0, a request raises `smi_o` on the clock edge that takes the write. `smi_o` then stays high until a cycle with `smi_ack` high.
- R5: If configuration bit 4 is 1, a request drives `irq_req` for exactly one cycle, beginning at the edge that takes the write. Exactly one bit is set, at index 10, 11, 12 or 15 for CPU-select bits [1:0] equal to 0, 1, 2 or 3. `smi_o` is left unchanged.
- R6: A request sets bit 4 of status register 0 (address 4). Writing to address 4 or 5 clears every bit written as 1 and leaves bits written as 0 unchanged.
- R7: While the lockout is active, a trigger write produces no SMI, no IRQ and no status change.
- R8: Writing address 6 loads the block counter, and address 6 reads back the live counter. The counter counts down only when the loaded value is 2 or more. Values 0 and 1 hold unchanged.
- R9: A running counter decrements once every TICKS_PER_PERIOD `tick` pulses. The step that would reach 1 instead sets the counter to 0, stops it and lifts the lockout. A lockout held while loading L (L ≥ 2) is therefore lifted after exactly (L−1)·TICKS_PER_PERIOD ticks.
- R10: A trigger write with bit 1 set restarts the tick count of the current period when the counter holds 2 or more. The counter value is not changed.
- R11: Address 7 reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address, shared by reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Single-cycle timebase enable |
| smi_ack | input | 1 | Clears `smi_o` |
| smi_o | output | 1 | SMI request level |
| irq_req | output | 16 | One-hot, one-cycle interrupt request |

## Verification
The bench builds the block with TICKS_PER_PERIOD set to 3. With that setting, every loaded count from 0 to 6 can be followed tick by tick down to its release in a few dozen cycles. The expected counter value after k ticks is computed as L − ⌊k/3⌋, clamped to 0 once it would reach 1. Under this small setting the bench also covers all four interrupt selections, the exact tick on which a lockout lifts, and a restart placed one tick before a period ends.

// File: rtl/swsmi_pkg.sv
// Package: shared register addresses, field positions and masks for the
// software SMI generator. Assumes a 3-bit register address space.
package swsmi_pkg;

    localparam int DATA_W    = 8;
    localparam int IRQ_LINES = 16;

    typedef enum logic [2:0] {
        RA_CFG    = 3'd0,
        RA_CPUSEL = 3'd1,
        RA_SELLO  = 3'd2,
        RA_SELHI  = 3'd3,
        RA_STS0   = 3'd4,
        RA_STS1   = 3'd5,
        RA_BCNT   = 3'd6,
        RA_TRIG   = 3'd7
    } reg_addr_e;

    localparam logic [DATA_W-1:0] CPUSEL_MASK = 8'h9F;
    localparam logic [DATA_W-1:0] SELHI_MASK  = 8'h7F;

    localparam int CFG_EN_BIT    = 7;
    localparam int CFG_ROUTE_BIT = 4;
    localparam int SEL_SOFT_BIT  = 4;
    localparam int STS_SOFT_BIT  = 4;
    localparam int TRIG_FIRE_BIT = 0;
    localparam int TRIG_RST_BIT  = 1;

    // Maps the 2-bit CPU-select field to a one-hot interrupt vector.
    function automatic logic [IRQ_LINES-1:0] irq_onehot(input logic [1:0] idx);
        logic [IRQ_LINES-1:0] v;
        v = '0;
        case (idx)
            2'd0:    v[10] = 1'b1;
            2'd1:    v[11] = 1'b1;
            2'd2:    v[12] = 1'b1;
            default: v[15] = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/swsmi_regs.sv
// Module: register file for the SMI generator. Holds the configuration,
// CPU-select, request-select and request-status registers and muxes the read
// data. Assumes one write port and combinational reads; the block counter
// value is supplied by the timer.
module swsmi_regs
    import swsmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_soft_sts,
    input  logic [DATA_W-1:0] cnt_value,
    output logic [DATA_W-1:0] rdata,
    output logic              pm_enable,
    output logic              route_irq,
    output logic              soft_sel,
    output logic [1:0]        cpu_idx
);

    logic [DATA_W-1:0] cfg_q, cpusel_q, sello_q, selhi_q, sts0_q, sts1_q;

    // Configuration and selection registers with their write masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cpusel_q <= '0;
            sello_q  <= '0;
            selhi_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CFG:    cfg_q    <= wdata;
                RA_CPUSEL: cpusel_q <= wdata & CPUSEL_MASK;
                RA_SELLO:  sello_q  <= wdata;
                RA_SELHI:  selhi_q  <= wdata & SELHI_MASK;
                default: ;
            endcase
        end
    end

    // Sticky status: hardware sets, writes of one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts0_q <= '0;
            sts1_q <= '0;
        end else begin
            if (wr_en && addr == RA_STS0)
                sts0_q <= sts0_q & ~wdata;
            else if (set_soft_sts)
                sts0_q[STS_SOFT_BIT] <= 1'b1;
            if (wr_en && addr == RA_STS1)
                sts1_q <= sts1_q & ~wdata;
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (addr)
            RA_CFG:    rdata = cfg_q;
            RA_CPUSEL: rdata = cpusel_q;
            RA_SELLO:  rdata = sello_q;
            RA_SELHI:  rdata = selhi_q;
            RA_STS0:   rdata = sts0_q;
            RA_STS1:   rdata = sts1_q;
            RA_BCNT:   rdata = cnt_value;
            default:   rdata = '0;
        endcase
    end

    assign pm_enable = cfg_q[CFG_EN_BIT];
    assign route_irq = cfg_q[CFG_ROUTE_BIT];
    assign soft_sel  = sello_q[SEL_SOFT_BIT];
    assign cpu_idx   = cpusel_q[1:0];

    AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_soft_sts |=> sts0_q[STS_SOFT_BIT]); // R6
    AST_SELHI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (selhi_q & ~SELHI_MASK) == '0); // R2

endmodule

// File: rtl/swsmi_blk_timer.sv
// Module: lockout timer. A prescaler divides the tick input by
// TICKS_PER_PERIOD; each full period decrements the counter. Assumes tick is
// a single-cycle enable. Loads of 0 or 1 leave the counter stopped.
module swsmi_blk_timer #(
    parameter int TICKS_PER_PERIOD = 35,
    parameter int CNT_W            = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             release_o
);

    localparam int PRE_W = (TICKS_PER_PERIOD > 1) ? $clog2(TICKS_PER_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

    logic running;
    logic period_done;
    logic restart_ok;

    assign restart_ok = restart && (cnt >= CNT_TWO);

    generate
        if (TICKS_PER_PERIOD == 1) begin : g_direct
            assign period_done = running && tick;
        end else begin : g_prescale
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_PERIOD - 1);
            logic [PRE_W-1:0] pre_q;
            // Prescaler: counts ticks within the current period.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (load || restart_ok)
                    pre_q <= '0;
                else if (running && tick)
                    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
            end
            assign period_done = running && tick && (pre_q == PRE_LAST);
        end
    endgenerate

    // Counter and run flag: load, restart, then per-period decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            running <= (load_val >= CNT_TWO);
        end else if (restart_ok) begin
            running <= 1'b1;
        end else if (period_done) begin
            if (cnt == CNT_TWO) begin
                cnt     <= '0;
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign release_o = period_done && (cnt == CNT_TWO) && !load && !restart_ok;

    AST_RUN_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt >= CNT_TWO)); // R8
    AST_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (cnt == '0)); // R9

endmodule

// File: rtl/swsmi_gen.sv
// Module: top of the software SMI generator. Decodes trigger and count writes,
// qualifies a request, holds the lockout flag, and drives the SMI level or a
// one-cycle IRQ vector. Assumes synchronous active-low reset.
module swsmi_gen
    import swsmi_pkg::*;
#(
    parameter int TICKS_PER_PERIOD = 35
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 tick,
    input  logic                 smi_ack,
    output logic                 smi_o,
    output logic [15:0]          irq_req
);

    logic pm_enable, route_irq, soft_sel;
    logic [1:0] cpu_idx;
    logic [DATA_W-1:0] cnt_value;
    logic trig_wr, fire, load, restart, release_w;
    logic blocked_q;

    assign trig_wr = reg_wr && (reg_addr == RA_TRIG);
    assign load    = reg_wr && (reg_addr == RA_BCNT);
    assign restart = trig_wr && reg_wdata[TRIG_RST_BIT];
    assign fire    = trig_wr && reg_wdata[TRIG_FIRE_BIT] && pm_enable
                     && soft_sel && !blocked_q;

    swsmi_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .set_soft_sts (fire),
        .cnt_value    (cnt_value),
        .rdata        (reg_rdata),
        .pm_enable    (pm_enable),
        .route_irq    (route_irq),
        .soft_sel     (soft_sel),
        .cpu_idx      (cpu_idx)
    );

    swsmi_blk_timer #(
        .TICKS_PER_PERIOD (TICKS_PER_PERIOD),
        .CNT_W            (DATA_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .load_val  (reg_wdata),
        .restart   (restart),
        .cnt       (cnt_value),
        .release_o (release_w)
    );

    // Lockout flag: set by a request, cleared when the counter runs out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blocked_q <= 1'b0;
        else if (fire)
            blocked_q <= 1'b1;
        else if (release_w)
            blocked_q <= 1'b0;
    end

    // SMI level: set by a direct request, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            smi_o <= 1'b0;
        else if (fire && !route_irq)
            smi_o <= 1'b1;
        else if (smi_ack)
            smi_o <= 1'b0;
    end

    // IRQ vector: one-cycle one-hot pulse for a routed request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_req <= '0;
        else if (fire && route_irq)
            irq_req <= irq_onehot(cpu_idx);
        else
            irq_req <= '0;
    end

    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req)); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |=> (irq_req == '0)); // R5
    AST_SMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_o && !smi_ack) |=> smi_o); // R4
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_q && !release_w) |=> ((irq_req == '0) && !$rose(smi_o))); // R7

endmodule

// File: tb/sim_swsmi_gen.sv
module sim_swsmi_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        tick = 1'b0;
    logic        smi_ack = 1'b0;
    logic        smi_o;
    logic [15:0] irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swsmi_gen #(.TICKS_PER_PERIOD(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .smi_ack(smi_ack), .smi_o(smi_o), .irq_req(irq_req)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic ack();
        @(negedge clk); smi_ack = 1'b1;
        @(negedge clk); smi_ack = 1'b0;
    endtask

    // Lifts a lockout: load 2, one full period.
    task automatic unblock();
        wr(3'd6, 8'd2);
        ticks(NT);
    endtask

    function automatic int exp_cnt(input int l, input int k);
        int v;
        if (l < 2) return l;
        v = l - (k / NT);
        return (v <= 1) ? 0 : v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [15:0] tbl [4];
        tbl[0] = 16'h0400; tbl[1] = 16'h0800; tbl[2] = 16'h1000; tbl[3] = 16'h8000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(16'(d), 16'h0, "R1");
        end
        chk(16'(smi_o), 16'h0, "R1");
        chk(irq_req, 16'h0, "R1");

        // R2: write masks
        begin
            logic [7:0] msk [4];
            msk[0] = 8'hFF; msk[1] = 8'h9F; msk[2] = 8'hFF; msk[3] = 8'h7F;
            for (int a = 0; a < 4; a++) begin
                wr(3'(a), 8'hFF); rd(3'(a), d); chk(16'(d), 16'(msk[a]), "R2");
                wr(3'(a), 8'h5A); rd(3'(a), d); chk(16'(d), 16'(8'h5A & msk[a]), "R2");
                wr(3'(a), 8'h00);
            end
        end

        // R11: trigger address reads zero
        rd(3'd7, d); chk(16'(d), 16'h0, "R11");

        // R3: each missing condition blocks the request
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h0, "R3");
        wr(3'd0, 8'h80);
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h0, "R3");
        wr(3'd2, 8'h10);
        wr(3'd7, 8'h02); chk(16'(smi_o), 16'h0, "R3");
        rd(3'd4, d); chk(16'(d), 16'h0, "R3");
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h1, "R3");

        // R4: SMI held until acknowledge
        ticks(2); chk(16'(smi_o), 16'h1, "R4");
        chk(irq_req, 16'h0, "R4");
        ack(); chk(16'(smi_o), 16'h0, "R4");

        // R6: status bit 4 set, write-one-to-clear
        rd(3'd4, d); chk(16'(d), 16'h10, "R6");
        wr(3'd4, 8'hEF); rd(3'd4, d); chk(16'(d), 16'h10, "R6");
        wr(3'd4, 8'h10); rd(3'd4, d); chk(16'(d), 16'h0, "R6");

        // R7: locked out (still blocked from above)
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h0, "R7");
        rd(3'd4, d); chk(16'(d), 16'h0, "R7");
        unblock();

        // R5: IRQ routing over all four selections
        wr(3'd0, 8'h90);
        for (int i = 0; i < 4; i++) begin
            wr(3'd1, 8'(i));
            wr(3'd7, 8'h01);
            chk(irq_req, tbl[i], "R5");
            chk(16'(smi_o), 16'h0, "R5");
            @(negedge clk); chk(irq_req, 16'h0, "R5");
            wr(3'd7, 8'h01); chk(irq_req, 16'h0, "R7");
            wr(3'd4, 8'hFF);
            unblock();
        end

        // R8/R9: counter sweep over loaded values 0..6
        for (int l = 0; l <= 6; l++) begin
            wr(3'd6, 8'(l));
            for (int k = 0; k <= l * NT + 2; k++) begin
                rd(3'd6, d);
                chk(16'(d), 16'(exp_cnt(l, k)), (l < 2) ? "R8" : "R9");
                ticks(1);
            end
        end

        // R9: exact release tick for a lockout with L = 4
        wr(3'd0, 8'h80);
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h1, "R9");
        ack();
        wr(3'd6, 8'd4);
        ticks(3 * NT - 1);
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h0, "R9");
        ticks(1);
        wr(3'd7, 8'h01); chk(16'(smi_o), 16'h1, "R9");
        ack();
        unblock();

        // R10: restart of the current period
        wr(3'd6, 8'd5);
        ticks(NT - 1);
        wr(3'd7, 8'h02);
        rd(3'd6, d); chk(16'(d), 16'd5, "R10");
        ticks(NT - 1);
        rd(3'd6, d); chk(16'(d), 16'd5, "R10");
        ticks(1);
        rd(3'd6, d); chk(16'(d), 16'd4, "R10");
        chk(16'(smi_o), 16'h0, "R10");
        wr(3'd6, 8'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule